// File: doc/BRIEF.md
# Trigger Combiner and Capture Controller

This block decides when an on-chip logic analyzer should capture, then records what it saw. Up to four match flags come in from external comparators. They are combined into a trigger in one of two ways. In Boolean mode a mask chooses which flags take part, and they are joined by AND or by OR. In sequence mode the flags must appear in a programmed order, stage by stage. A host force command also triggers at once, whatever the flags are doing.

While armed, the block writes one probe sample per clock into a circular region of its sample store. The store is cut into a configured number of windows, each a configured number of samples deep, and each window takes exactly one trigger. The position setting fixes where the trigger sample lands inside its window, so history from before the trigger is kept. Once every window has been filled the block reports done. Software then reads each window in time order through a combinational read port. A valid flag marks the samples that were really captured.

Top module: `tcap_top`

## Requirements
- R1: With sequence mode off and OR mode off, a trigger occurs in the first armed cycle in which every match bit selected by `cfg_mask_i` is high. An all-zero mask never triggers in this mode.
- R2: With sequence mode off and OR mode on, a trigger occurs in the first armed cycle in which any masked match bit is high. Unmasked bits have no effect.
- R3: In sequence mode there are `cfg_seq_last_i`+1 stages. Stage k waits for `match_i[sel_k]`, where sel_k is the field `cfg_seq_sel_i[2k+1:2k]`. The sequencer moves up at most one stage per cycle, and the trigger is the cycle in which the last stage sees its flag. Flags that do not belong to the current stage are ignored.
- R4: The sequencer returns to stage 0 on every arm pulse and at the start of every new window.
- R5: While capture is in progress, a high `force_i` triggers in that cycle. When the block is idle or done, `force_i` is ignored.
- R6: A capture uses `cfg_win_cnt_i` windows (1 to 4) of `cfg_depth_i` samples each, with `cfg_win_cnt_i`×`cfg_depth_i` ≤ 64. Each window takes one trigger. The next window starts capturing in the cycle after the previous one ends. `done_o` rises after the last window ends and stays high until the next arm.
- R7: The probe value present at the trigger edge is stored at logical offset `cfg_pos_i` of its window (`cfg_pos_i` < `cfg_depth_i`). Logical offset i holds the sample taken i−`cfg_pos_i` cycles from the trigger. The window closes on the edge `cfg_depth_i`−`cfg_pos_i`−1 cycles after the trigger.
- R8: If fewer than `cfg_pos_i` samples were taken in a window before its trigger, the offsets that would hold the missing older samples read with `rd_ok_o` low and `rd_data_o` zero.
- R9: `trig_idx_o` gives, for window `rd_win_i`, the physical slot of the trigger sample. This equals (trigger cycle − window start cycle) mod `cfg_depth_i`.
- R10: After an arm pulse, `armed_o` is high and both `triggered_o` and `done_o` are low. `triggered_o` stays high from the first trigger until the next arm. `armed_o` and `done_o` are never high together.
- R11: While `done_o` is low, `rd_ok_o` is low and `rd_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Pulse: start a new capture |
| force_i | input | 1 | Immediate trigger command |
| match_i | input | 4 | Match flags from the comparators |
| probe_i | input | 8 | Probe sample |
| cfg_seq_mode_i | input | 1 | 1 selects sequence mode |
| cfg_or_mode_i | input | 1 | Boolean join: 1 = OR, 0 = AND |
| cfg_mask_i | input | 4 | Flags taking part in Boolean mode |
| cfg_seq_last_i | input | 2 | Index of the last sequence stage |
| cfg_seq_sel_i | input | 8 | Flag index per stage, 2 bits each |
| cfg_depth_i | input | 7 | Samples per window |
| cfg_pos_i | input | 7 | Trigger offset inside a window |
| cfg_win_cnt_i | input | 3 | Number of windows |
| rd_win_i | input | 2 | Read window select |
| rd_off_i | input | 6 | Read logical offset |
| rd_data_o | output | 8 | Read sample |
| rd_ok_o | output | 1 | Read sample is valid |
| trig_idx_o | output | 6 | Trigger slot of the selected window |
| armed_o | output | 1 | Capture in progress |
| triggered_o | output | 1 | At least one trigger since arm |
| done_o | output | 1 | All windows filled |

## Verification
The trigger decision and the sample write both happen on the edge at which the stimulus is sampled. `armed_o`, `triggered_o` and `done_o` therefore change one edge after the stimulus. The bench drives each stimulus on a falling edge, notes the index of the rising edge that will sample it, and reads the flags on a following falling edge. The read port is combinational, so each read is sampled 1 ns after the address is set. A window's closing edge is trigger edge + depth − pos − 1. For the last window, `done_o` is checked low just before that edge and high just after it. Expected samples come from a bench record of the probe value at each rising edge.

// File: rtl/tcap_pkg.sv
`timescale 1ns/1ps
package tcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2,
        ST_DONE = 2'd3
    } cap_state_e;

    typedef struct packed {
        logic seq_mode;
        logic or_mode;
    } comb_mode_t;

    // Ring slot of logical offset 'off' when the trigger sits in slot 'trig_pt'
    // and at logical offset 'pos' of a ring of 'depth' slots.
    function automatic int unsigned ring_map(input int unsigned trig_pt,
                                             input int unsigned off,
                                             input int unsigned pos,
                                             input int unsigned depth);
        int unsigned u;
        u = trig_pt + off + depth - pos;
        if (u >= 2 * depth)
            u = u - 2 * depth;
        else if (u >= depth)
            u = u - depth;
        return u;
    endfunction

endpackage

// File: rtl/trig_combiner.sv
`timescale 1ns/1ps
module trig_combiner
    import tcap_pkg::*;
#(
    parameter int NUM_MATCH  = 4,
    parameter int SEQ_STAGES = 4,
    localparam int SEL_W = $clog2(NUM_MATCH),
    localparam int STG_W = $clog2(SEQ_STAGES)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en_i,
    input  logic                        clr_i,
    input  comb_mode_t                  mode_i,
    input  logic [NUM_MATCH-1:0]        mask_i,
    input  logic [STG_W-1:0]            seq_last_i,
    input  logic [SEQ_STAGES*SEL_W-1:0] seq_sel_i,
    input  logic [NUM_MATCH-1:0]        match_i,
    output logic                        hit_o
);

    logic [STG_W-1:0]     stage_q;
    logic [SEL_W-1:0]     cur_sel;
    logic [NUM_MATCH-1:0] masked;
    logic                 bool_hit;
    logic                 stage_match;
    logic                 seq_hit;

    always_comb begin
        masked = match_i & mask_i;
        if (mode_i.or_mode)
            bool_hit = |masked;
        else
            bool_hit = (mask_i != '0) && (masked == mask_i);
        cur_sel     = seq_sel_i[stage_q*SEL_W +: SEL_W];
        stage_match = match_i[cur_sel];
        seq_hit     = stage_match && (stage_q == seq_last_i);
    end

    assign hit_o = en_i && (mode_i.seq_mode ? seq_hit : bool_hit);

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            stage_q <= '0;
        else if (en_i && mode_i.seq_mode && stage_match && (stage_q != seq_last_i))
            stage_q <= stage_q + STG_W'(1);
    end

endmodule

// File: rtl/capture_ctrl.sv
`timescale 1ns/1ps
module capture_ctrl
    import tcap_pkg::*;
#(
    parameter int MEM_DEPTH = 64,
    parameter int MAX_WIN   = 4,
    localparam int AW  = $clog2(MEM_DEPTH),
    localparam int DW  = AW + 1,
    localparam int WCW = $clog2(MAX_WIN) + 1,
    localparam int WW  = $clog2(MAX_WIN)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  arm_i,
    input  logic                  force_i,
    input  logic                  hit_i,
    input  logic [DW-1:0]         depth_i,
    input  logic [DW-1:0]         pos_i,
    input  logic [WCW-1:0]        win_cnt_i,
    output cap_state_e            state_o,
    output logic                  seq_clr_o,
    output logic                  we_o,
    output logic [AW-1:0]         waddr_o,
    output logic [MAX_WIN*AW-1:0] trig_pt_o,
    output logic [MAX_WIN*DW-1:0] kept_o,
    output logic                  triggered_o
);

    cap_state_e      st_q;
    logic [WCW-1:0]  win_q;
    logic [AW-1:0]   wp_q;
    logic [DW-1:0]   pre_q;
    logic [DW-1:0]   left_q;
    logic            trig_q;
    logic [AW-1:0]   pt_q   [MAX_WIN];
    logic [DW-1:0]   kept_q [MAX_WIN];

    logic               fire;
    logic               win_end;
    logic               last_win;
    logic [AW-1:0]      wp_nxt;
    logic [DW-1:0]      after_trig;
    logic [WCW+DW-1:0]  base;

    always_comb begin
        fire       = (st_q == ST_PRE) && (hit_i || force_i);
        wp_nxt     = (({1'b0, wp_q} + DW'(1)) == depth_i) ? '0 : wp_q + AW'(1);
        after_trig = depth_i - pos_i - DW'(1);
        win_end    = (fire && (after_trig == '0)) ||
                     ((st_q == ST_POST) && (left_q == DW'(1)));
        last_win   = ((win_q + WCW'(1)) == win_cnt_i);
        base       = (WCW+DW)'(win_q) * (WCW+DW)'(depth_i);
        waddr_o    = base[AW-1:0] + wp_q;
        we_o       = (st_q == ST_PRE) || (st_q == ST_POST);
        seq_clr_o  = arm_i || (win_end && !last_win);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            win_q  <= '0;
            wp_q   <= '0;
            pre_q  <= '0;
            left_q <= '0;
            trig_q <= 1'b0;
            for (int k = 0; k < MAX_WIN; k++) begin
                pt_q[k]   <= '0;
                kept_q[k] <= '0;
            end
        end else if (arm_i) begin
            st_q   <= ST_PRE;
            win_q  <= '0;
            wp_q   <= '0;
            pre_q  <= '0;
            left_q <= '0;
            trig_q <= 1'b0;
            for (int k = 0; k < MAX_WIN; k++) begin
                pt_q[k]   <= '0;
                kept_q[k] <= '0;
            end
        end else begin
            case (st_q)
                ST_PRE: begin
                    wp_q <= wp_nxt;
                    if (fire) begin
                        trig_q               <= 1'b1;
                        pt_q[win_q[WW-1:0]]   <= wp_q;
                        kept_q[win_q[WW-1:0]] <= pre_q;
                        left_q               <= after_trig;
                        st_q                 <= ST_POST;
                    end else if (pre_q != pos_i) begin
                        pre_q <= pre_q + DW'(1);
                    end
                end
                ST_POST: begin
                    wp_q   <= wp_nxt;
                    left_q <= left_q - DW'(1);
                end
                default: ;
            endcase
            if (win_end) begin
                if (last_win) begin
                    st_q <= ST_DONE;
                end else begin
                    st_q  <= ST_PRE;
                    win_q <= win_q + WCW'(1);
                    wp_q  <= '0;
                    pre_q <= '0;
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < MAX_WIN; g++) begin : g_flat
            assign trig_pt_o[g*AW +: AW] = pt_q[g];
            assign kept_o[g*DW +: DW]    = kept_q[g];
        end
    endgenerate

    assign state_o     = st_q;
    assign triggered_o = trig_q;

endmodule

// File: rtl/capture_mem.sv
`timescale 1ns/1ps
module capture_mem
    import tcap_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MEM_DEPTH = 64,
    parameter int MAX_WIN   = 4,
    localparam int AW  = $clog2(MEM_DEPTH),
    localparam int DW  = AW + 1,
    localparam int WCW = $clog2(MAX_WIN) + 1,
    localparam int WW  = $clog2(MAX_WIN)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              done_i,
    input  logic [DW-1:0]     depth_i,
    input  logic [DW-1:0]     pos_i,
    input  logic [WCW-1:0]    win_cnt_i,
    input  logic [WW-1:0]     rd_win_i,
    input  logic [AW-1:0]     rd_off_i,
    input  logic [AW-1:0]     trig_pt_i,
    input  logic [DW-1:0]     kept_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_ok_o
);

    logic [DATA_W-1:0] store [MEM_DEPTH];

    logic [AW-1:0]     phys;
    logic [WW+DW-1:0]  rbase;
    logic [AW-1:0]     raddr;
    logic [DW-1:0]     gap;

    always_ff @(posedge clk) begin
        if (we_i)
            store[waddr_i] <= wdata_i;
    end

    always_comb begin
        phys  = AW'(ring_map(32'(trig_pt_i), 32'(rd_off_i), 32'(pos_i), 32'(depth_i)));
        rbase = (WW+DW)'(rd_win_i) * (WW+DW)'(depth_i);
        raddr = rbase[AW-1:0] + phys;
        gap   = pos_i - kept_i;
        rd_ok_o = done_i &&
                  ({1'b0, rd_off_i} >= gap) &&
                  ({1'b0, rd_off_i} < depth_i) &&
                  (WCW'(rd_win_i) < win_cnt_i);
        rd_data_o = rd_ok_o ? store[raddr] : '0;
    end

endmodule

// File: rtl/tcap_top.sv
`timescale 1ns/1ps
module tcap_top
    import tcap_pkg::*;
#(
    parameter int NUM_MATCH  = 4,
    parameter int DATA_W     = 8,
    parameter int MEM_DEPTH  = 64,
    parameter int MAX_WIN    = 4,
    parameter int SEQ_STAGES = 4,
    localparam int SEL_W = $clog2(NUM_MATCH),
    localparam int STG_W = $clog2(SEQ_STAGES),
    localparam int AW    = $clog2(MEM_DEPTH),
    localparam int DW    = AW + 1,
    localparam int WCW   = $clog2(MAX_WIN) + 1,
    localparam int WW    = $clog2(MAX_WIN)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        arm_i,
    input  logic                        force_i,
    input  logic [NUM_MATCH-1:0]        match_i,
    input  logic [DATA_W-1:0]           probe_i,
    input  logic                        cfg_seq_mode_i,
    input  logic                        cfg_or_mode_i,
    input  logic [NUM_MATCH-1:0]        cfg_mask_i,
    input  logic [STG_W-1:0]            cfg_seq_last_i,
    input  logic [SEQ_STAGES*SEL_W-1:0] cfg_seq_sel_i,
    input  logic [DW-1:0]               cfg_depth_i,
    input  logic [DW-1:0]               cfg_pos_i,
    input  logic [WCW-1:0]              cfg_win_cnt_i,
    input  logic [WW-1:0]               rd_win_i,
    input  logic [AW-1:0]               rd_off_i,
    output logic [DATA_W-1:0]           rd_data_o,
    output logic                        rd_ok_o,
    output logic [AW-1:0]               trig_idx_o,
    output logic                        armed_o,
    output logic                        triggered_o,
    output logic                        done_o
);

    comb_mode_t            mode;
    cap_state_e            state;
    logic                  hit;
    logic                  seq_clr;
    logic                  we;
    logic [AW-1:0]         waddr;
    logic [MAX_WIN*AW-1:0] pt_flat;
    logic [MAX_WIN*DW-1:0] kept_flat;
    logic [DW-1:0]         kept_sel;

    assign mode = '{seq_mode: cfg_seq_mode_i, or_mode: cfg_or_mode_i};

    trig_combiner #(.NUM_MATCH(NUM_MATCH), .SEQ_STAGES(SEQ_STAGES)) u_comb (
        .clk        (clk),
        .rst        (rst),
        .en_i       (state == ST_PRE),
        .clr_i      (seq_clr),
        .mode_i     (mode),
        .mask_i     (cfg_mask_i),
        .seq_last_i (cfg_seq_last_i),
        .seq_sel_i  (cfg_seq_sel_i),
        .match_i    (match_i),
        .hit_o      (hit)
    );

    capture_ctrl #(.MEM_DEPTH(MEM_DEPTH), .MAX_WIN(MAX_WIN)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (arm_i),
        .force_i     (force_i),
        .hit_i       (hit),
        .depth_i     (cfg_depth_i),
        .pos_i       (cfg_pos_i),
        .win_cnt_i   (cfg_win_cnt_i),
        .state_o     (state),
        .seq_clr_o   (seq_clr),
        .we_o        (we),
        .waddr_o     (waddr),
        .trig_pt_o   (pt_flat),
        .kept_o      (kept_flat),
        .triggered_o (triggered_o)
    );

    assign trig_idx_o = pt_flat[rd_win_i*AW +: AW];
    assign kept_sel   = kept_flat[rd_win_i*DW +: DW];

    capture_mem #(.DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH), .MAX_WIN(MAX_WIN)) u_mem (
        .clk       (clk),
        .we_i      (we),
        .waddr_i   (waddr),
        .wdata_i   (probe_i),
        .done_i    (done_o),
        .depth_i   (cfg_depth_i),
        .pos_i     (cfg_pos_i),
        .win_cnt_i (cfg_win_cnt_i),
        .rd_win_i  (rd_win_i),
        .rd_off_i  (rd_off_i),
        .trig_pt_i (trig_idx_o),
        .kept_i    (kept_sel),
        .rd_data_o (rd_data_o),
        .rd_ok_o   (rd_ok_o)
    );

    assign armed_o = (state == ST_PRE) || (state == ST_POST);
    assign done_o  = (state == ST_DONE);

endmodule

// File: rtl/tcap_checker.sv
`timescale 1ns/1ps
module tcap_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              arm_i,
    input logic              force_i,
    input logic              armed_o,
    input logic              triggered_o,
    input logic              done_o,
    input logic              rd_ok_o,
    input logic [DATA_W-1:0] rd_data_o
);

    a_r10_arm_clears: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> (armed_o && !done_o && !triggered_o));

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(armed_o && done_o));

    a_r10_trig_sticky: assert property (@(posedge clk) disable iff (rst)
        (triggered_o && !arm_i) |=> triggered_o);

    a_r5_force_triggers: assert property (@(posedge clk) disable iff (rst)
        (armed_o && force_i && !arm_i) |=> triggered_o);

    a_r6_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done_o && !arm_i) |=> done_o);

    a_r11_read_gated: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> (!rd_ok_o && (rd_data_o == '0)));

endmodule

bind tcap_top tcap_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .arm_i       (arm_i),
    .force_i     (force_i),
    .armed_o     (armed_o),
    .triggered_o (triggered_o),
    .done_o      (done_o),
    .rd_ok_o     (rd_ok_o),
    .rd_data_o   (rd_data_o)
);

// File: tb/sim_tcap_top.sv
`timescale 1ns/1ps
module sim_tcap_top;

    localparam int NM = 4;
    localparam int DATA_W = 8;
    localparam int HIST = 4096;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       arm_i = 1'b0;
    logic       force_i = 1'b0;
    logic [3:0] match_i = '0;
    logic [7:0] probe_i = '0;
    logic       cfg_seq_mode_i = 1'b0;
    logic       cfg_or_mode_i = 1'b0;
    logic [3:0] cfg_mask_i = '0;
    logic [1:0] cfg_seq_last_i = '0;
    logic [7:0] cfg_seq_sel_i = '0;
    logic [6:0] cfg_depth_i = 7'd8;
    logic [6:0] cfg_pos_i = 7'd0;
    logic [2:0] cfg_win_cnt_i = 3'd1;
    logic [1:0] rd_win_i = '0;
    logic [5:0] rd_off_i = '0;
    logic [7:0] rd_data_o;
    logic       rd_ok_o;
    logic [5:0] trig_idx_o;
    logic       armed_o, triggered_o, done_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int ca;
    int st_c [4];
    int ct_c [4];
    logic [7:0] hist [HIST];

    tcap_top u0 (.*);

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        hist[cyc % HIST] <= probe_i;
        cyc <= cyc + 1;
    end

    always @(negedge clk) probe_i <= 8'($urandom);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic seq, input logic orm, input logic [3:0] mask,
                           input logic [1:0] last, input logic [7:0] sel,
                           input int depth, input int pos, input int nwin);
        @(negedge clk);
        cfg_seq_mode_i = seq;
        cfg_or_mode_i  = orm;
        cfg_mask_i     = mask;
        cfg_seq_last_i = last;
        cfg_seq_sel_i  = sel;
        cfg_depth_i    = 7'(depth);
        cfg_pos_i      = 7'(pos);
        cfg_win_cnt_i  = 3'(nwin);
    endtask

    task automatic arm_pulse();
        @(negedge clk);
        arm_i = 1'b1;
        ca = cyc;
        @(negedge clk);
        arm_i = 1'b0;
        st_c[0] = ca + 1;
    endtask

    task automatic pulse_match(input logic [3:0] pat, output int c);
        @(negedge clk);
        match_i = pat;
        c = cyc;
        @(negedge clk);
        match_i = '0;
    endtask

    task automatic pulse_force(output int c);
        @(negedge clk);
        force_i = 1'b1;
        c = cyc;
        @(negedge clk);
        force_i = 1'b0;
    endtask

    // Wait out the rest of window w after its trigger at ct_c[w].
    task automatic close_window(input int w, input int depth, input int pos, input int nwin);
        int rem;
        rem = depth - pos - 1;
        if (w + 1 < nwin) begin
            repeat (rem) @(negedge clk);
            st_c[w+1] = ct_c[w] + depth - pos;
        end else begin
            if (rem > 0) begin
                repeat (rem - 1) @(negedge clk);
                chk("R7 window still open before closing edge", 32'(done_o), 32'd0);
                @(negedge clk);
            end
            chk("R6 done after last window", 32'(done_o), 32'd1);
        end
    endtask

    task automatic verify(input int depth, input int pos, input int nwin);
        int sc;
        logic v;
        chk("R10 armed low when done", 32'(armed_o), 32'd0);
        chk("R10 triggered high when done", 32'(triggered_o), 32'd1);
        for (int w = 0; w < nwin; w++) begin
            rd_win_i = 2'(w);
            rd_off_i = '0;
            #1;
            chk("R9 trigger slot", 32'(trig_idx_o), 32'((ct_c[w] - st_c[w]) % depth));
            for (int i = 0; i < depth; i++) begin
                rd_off_i = 6'(i);
                #1;
                sc = ct_c[w] - pos + i;
                v = (sc >= st_c[w]);
                chk("R8 sample valid flag", 32'(rd_ok_o), 32'(v));
                chk("R7 sample data", 32'(rd_data_o), v ? 32'(hist[sc % HIST]) : 32'd0);
            end
        end
    endtask

    task automatic run_force(input int depth, input int pos, input int nwin, input int maxgap);
        set_cfg(1'b0, 1'b0, 4'b0000, 2'd0, 8'd0, depth, pos, nwin);
        arm_pulse();
        for (int w = 0; w < nwin; w++) begin
            repeat ($urandom % (maxgap + 1)) @(negedge clk);
            pulse_force(ct_c[w]);
            close_window(w, depth, pos, nwin);
        end
        verify(depth, pos, nwin);
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int c;
        int d, p, nw;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset armed", 32'(armed_o), 32'd0);
        chk("R10 reset triggered", 32'(triggered_o), 32'd0);
        chk("R10 reset done", 32'(done_o), 32'd0);
        chk("R11 reset read gated", 32'(rd_ok_o), 32'd0);

        // R5: force ignored while idle
        pulse_force(c);
        chk("R5 force ignored when idle (triggered)", 32'(triggered_o), 32'd0);
        chk("R5 force ignored when idle (armed)", 32'(armed_o), 32'd0);

        // R1: AND, partial match and zero mask
        set_cfg(1'b0, 1'b0, 4'b0000, 2'd0, 8'd0, 8, 3, 1);
        arm_pulse();
        chk("R10 armed after arm", 32'(armed_o), 32'd1);
        chk("R11 read gated while armed", 32'(rd_ok_o), 32'd0);
        chk("R11 read data zero while armed", 32'(rd_data_o), 32'd0);
        pulse_match(4'b1111, c);
        chk("R1 zero mask never triggers", 32'(triggered_o), 32'd0);
        set_cfg(1'b0, 1'b0, 4'b0101, 2'd0, 8'd0, 8, 3, 1);
        arm_pulse();
        pulse_match(4'b0001, c);
        chk("R1 partial AND no trigger", 32'(triggered_o), 32'd0);
        repeat (3) @(negedge clk);
        pulse_match(4'b0111, ct_c[0]);
        chk("R1 full AND triggers", 32'(triggered_o), 32'd1);
        close_window(0, 8, 3, 1);
        verify(8, 3, 1);

        // R2: OR
        set_cfg(1'b0, 1'b1, 4'b0110, 2'd0, 8'd0, 6, 2, 1);
        arm_pulse();
        pulse_match(4'b1001, c);
        chk("R2 unmasked bits ignored", 32'(triggered_o), 32'd0);
        pulse_match(4'b0100, ct_c[0]);
        chk("R2 any masked bit triggers", 32'(triggered_o), 32'd1);
        close_window(0, 6, 2, 1);
        verify(6, 2, 1);

        // R3: sequence stage0=3, stage1=1, stage2=2
        set_cfg(1'b1, 1'b0, 4'b0000, 2'd2, {2'd0, 2'd2, 2'd1, 2'd3}, 8, 4, 1);
        arm_pulse();
        pulse_match(4'b0100, c);
        pulse_match(4'b1000, c);
        pulse_match(4'b0100, c);
        pulse_match(4'b0010, c);
        chk("R3 out-of-order flags do not trigger", 32'(triggered_o), 32'd0);
        pulse_match(4'b0100, ct_c[0]);
        chk("R3 ordered sequence triggers", 32'(triggered_o), 32'd1);
        close_window(0, 8, 4, 1);
        verify(8, 4, 1);

        // R4: re-arm returns the sequencer to stage 0
        set_cfg(1'b1, 1'b0, 4'b0000, 2'd2, {2'd0, 2'd2, 2'd1, 2'd3}, 8, 4, 1);
        arm_pulse();
        pulse_match(4'b1000, c);
        pulse_match(4'b0010, c);
        arm_pulse();
        pulse_match(4'b0100, c);
        chk("R4 sequencer cleared by arm", 32'(triggered_o), 32'd0);

        // R4: new window returns the sequencer to stage 0
        set_cfg(1'b1, 1'b0, 4'b0000, 2'd1, {2'd0, 2'd0, 2'd1, 2'd3}, 2, 1, 2);
        arm_pulse();
        pulse_match(4'b1000, c);
        pulse_match(4'b0010, ct_c[0]);
        st_c[1] = ct_c[0] + 1;
        pulse_match(4'b0010, c);
        chk("R4 sequencer cleared at window start", 32'(done_o), 32'd0);
        pulse_match(4'b1000, c);
        pulse_match(4'b0010, ct_c[1]);
        chk("R6 done after second window", 32'(done_o), 32'd1);
        verify(2, 1, 2);

        // R8: early trigger leaves missing history invalid
        set_cfg(1'b0, 1'b0, 4'b0000, 2'd0, 8'd0, 8, 6, 1);
        arm_pulse();
        @(negedge clk);
        force_i = 1'b1;
        ct_c[0] = cyc;
        @(negedge clk);
        force_i = 1'b0;
        close_window(0, 8, 6, 1);
        verify(8, 6, 1);

        // R6/R7 corners: position 0, position depth-1, full store
        run_force(16, 0, 4, 20);
        run_force(16, 15, 4, 20);
        run_force(64, 10, 1, 80);

        // Random windows, depths and positions
        for (int k = 0; k < 20; k++) begin
            d  = 2 + ($urandom % 15);
            nw = 1 + ($urandom % 4);
            p  = $urandom % d;
            run_force(d, p, nw, 24);
        end

        // R10: re-arm from done clears the flags
        arm_pulse();
        chk("R10 re-arm clears done", 32'(done_o), 32'd0);
        chk("R10 re-arm clears triggered", 32'(triggered_o), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule